// File: doc/BRIEF.md
# Register-Exchange Survivor Memory

This block holds the survivor paths of a hard-decision Viterbi decoder with the register-exchange method. Each trellis state owns a path register that always contains the decoded bit history along that state's survivor. On every accepted trellis step, an add-compare-select array supplies one decision bit per state and the index of the state with the best path metric. Every register then takes a copy of its chosen predecessor's register and appends the bit that the state itself stands for. The decoded output is the oldest bit held for the best state, so no traceback pass is needed.

The constraint length K sets the number of states, N = 2^(K-1). The register depth D defaults to five times K. A parameter selects how the registers are organised. In shift form the newest bit enters bit 0 and older bits move toward the top. In column form a write pointer walks across the columns and each step fills one of them. Both forms give the same result at the ports. The default K is 7, which keeps the default elaboration small; the intended K of 11 is a parameter setting.

Top module: `survivor_xchg_mem`

## Requirements
- R1: A synchronous reset clears every path register and the fill count, and `out_valid` is 0 in the cycle after any cycle with `rst` high.
- R2: `out_valid` is 1 in the cycle after an accepted step (`dec_valid` high) exactly when at least D steps have been accepted since reset counting that step; otherwise it is 0.
- R3: A cycle with `dec_valid` low changes no path register and leaves `out_bit` unchanged.
- R4: Decision convention: for state s, `dec_bits[s]`=1 selects predecessor {0, s[K-2:1]} and 0 selects predecessor {1, s[K-2:1]}.
- R5: The bit a state appends at a step is its own state number's LSB (even state gives 0, odd state gives 1).
- R6: After an accepted step t with t ≥ D-1, `out_bit` equals the LSB of the state reached by walking the survivor of `best_state` back D-1 steps through the decisions of R4.
- R7: With shift organisation, the new bit enters bit 0 of each register and the copied predecessor bits move one place toward the MSB; the output is the MSB of the best state's updated register.
- R8: With column organisation, a column pointer starts at D-1 after reset, each step writes the new bit into that column and moves the pointer down by one, wrapping from 0 to D-1; the output is the column written D-1 steps earlier. Port behaviour matches R7 exactly.
- R9: Fed with decisions from a correct Viterbi add-compare-select on a rate-1/2 code with sparse channel errors, the k-th valid output equals the k-th source bit.
- R10: A reset in the middle of a stream restarts the fill count, so `out_valid` stays 0 for the next D-1 accepted steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | A trellis step is presented this cycle |
| dec_bits | input | 2^(K-1) | Survivor decision per state (1 = upper predecessor) |
| best_state | input | K-1 | State with the best path metric after this step |
| out_valid | output | 1 | Decoded bit is valid |
| out_bit | output | 1 | Decoded bit, D-1 steps behind the step just accepted |

## Verification
The assertions watch, every cycle, that a valid output only follows an accepted step, that `out_bit` holds across idle cycles, that the fill count and column pointer stay in range, that reset silences the output, and that a full memory produces a valid output on each step. Whether the copied histories follow the right predecessor, whether each state appends the right bit, and whether both organisations agree can only be shown by the bench, which walks its stored decisions back D-1 steps on every step and compares both organisations against that walk. End-to-end correction under channel errors, and the restart after a mid-stream reset, likewise rest on the bench's scenarios.

// File: rtl/sxm_pkg.sv
package sxm_pkg;

  typedef enum logic {
    UPD_SHIFT  = 1'b0,
    UPD_SELECT = 1'b1
  } sxmUpdate_e;

  typedef struct packed {
    logic clearAll;
    logic stepEn;
    logic emitEn;
  } sxmStrobe_t;

endpackage

// File: rtl/sxm_ctrl.sv
module sxm_ctrl #(
  parameter int D  = 35,
  parameter int CW = $clog2(D)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 decValid,
  output sxm_pkg::sxmStrobe_t  strobe,
  output logic [CW-1:0]        colPtr
);

  localparam logic [CW-1:0] LAST = CW'(D - 1);

  logic [CW-1:0] fillCnt;
  logic          fillFull;

  assign fillFull = (fillCnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt <= '0;
      colPtr  <= LAST;
    end else if (decValid) begin
      if (!fillFull) fillCnt <= fillCnt + 1'b1;
      colPtr <= (colPtr == '0) ? LAST : colPtr - 1'b1;
    end
  end

  always_comb begin
    strobe.clearAll = rst;
    strobe.stepEn   = decValid & ~rst;
    strobe.emitEn   = decValid & ~rst & fillFull;
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    fillCnt <= LAST);  // R2
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
    colPtr <= LAST);  // R8
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (decValid && colPtr == '0) |=> colPtr == LAST);  // R8

endmodule

// File: rtl/sxm_datapath.sv
module sxm_datapath #(
  parameter int                  K      = 7,
  parameter int                  D      = 35,
  parameter int                  CW     = $clog2(D),
  parameter sxm_pkg::sxmUpdate_e UPDATE = sxm_pkg::UPD_SHIFT
) (
  input  logic                    clk,
  input  sxm_pkg::sxmStrobe_t     strobe,
  input  logic [CW-1:0]           colPtr,
  input  logic [(1<<(K-1))-1:0]   decBits,
  input  logic [K-2:0]            bestState,
  output logic                    outValid,
  output logic                    outBit
);

  localparam int N    = 1 << (K - 1);
  localparam int HALF = N / 2;

  logic [N-1:0][D-1:0] pathAll;
  logic [N-1:0][D-1:0] nextAll;
  logic [CW-1:0]       oldCol;
  logic                oldestBit;

  assign oldCol = (colPtr == '0) ? CW'(D - 1) : colPtr - 1'b1;

  for (genvar s = 0; s < N; s++) begin : g_state
    localparam int  UP_IDX = s >> 1;
    localparam int  LO_IDX = (s >> 1) + HALF;
    localparam logic OWN_BIT = ((s % 2) == 1);

    logic [D-1:0] pathReg;
    logic [D-1:0] picked;
    logic [D-1:0] nextReg;

    assign picked = decBits[s] ? pathAll[UP_IDX] : pathAll[LO_IDX];

    if (UPDATE == sxm_pkg::UPD_SHIFT) begin : g_shift
      assign nextReg = {picked[D-2:0], OWN_BIT};
    end else begin : g_select
      always_comb begin
        nextReg         = picked;
        nextReg[colPtr] = OWN_BIT;
      end
    end

    always_ff @(posedge clk) begin
      if (strobe.clearAll)    pathReg <= '0;
      else if (strobe.stepEn) pathReg <= nextReg;
    end

    assign pathAll[s] = pathReg;
    assign nextAll[s] = nextReg;
  end

  if (UPDATE == sxm_pkg::UPD_SHIFT) begin : g_out_shift
    assign oldestBit = nextAll[bestState][D-1];
  end else begin : g_out_select
    assign oldestBit = nextAll[bestState][oldCol];
  end

  always_ff @(posedge clk) begin
    if (strobe.clearAll) begin
      outValid <= 1'b0;
      outBit   <= 1'b0;
    end else begin
      outValid <= strobe.emitEn;
      if (strobe.stepEn) outBit <= oldestBit;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    strobe.clearAll |=> !outValid);  // R1
  AST_VALID_NEEDS_STEP: assert property (@(posedge clk) disable iff (strobe.clearAll)
    outValid |-> $past(strobe.stepEn));  // R2
  AST_FULL_EMITS: assert property (@(posedge clk) disable iff (strobe.clearAll)
    strobe.emitEn |=> outValid);  // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (strobe.clearAll)
    !strobe.stepEn |=> $stable(outBit));  // R3

endmodule

// File: rtl/survivor_xchg_mem.sv
module survivor_xchg_mem #(
  parameter int                  K      = 7,
  parameter int                  D      = 5 * K,
  parameter sxm_pkg::sxmUpdate_e UPDATE = sxm_pkg::UPD_SHIFT
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dec_valid,
  input  logic [(1<<(K-1))-1:0]  dec_bits,
  input  logic [K-2:0]           best_state,
  output logic                   out_valid,
  output logic                   out_bit
);

  localparam int CW = $clog2(D);

  sxm_pkg::sxmStrobe_t strobe;
  logic [CW-1:0]       colPtr;

  sxm_ctrl #(.D(D), .CW(CW)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .decValid (dec_valid),
    .strobe   (strobe),
    .colPtr   (colPtr)
  );

  sxm_datapath #(.K(K), .D(D), .CW(CW), .UPDATE(UPDATE)) i_datapath (
    .clk       (clk),
    .strobe    (strobe),
    .colPtr    (colPtr),
    .decBits   (dec_bits),
    .bestState (best_state),
    .outValid  (out_valid),
    .outBit    (out_bit)
  );

endmodule

// File: tb/test_survivor_xchg_mem.sv
module test_survivor_xchg_mem;

  localparam int CLK_PERIOD = 10;
  localparam int K  = 5;
  localparam int D  = 25;
  localparam int N  = 1 << (K - 1);
  localparam int G0 = 5'b10011;
  localparam int G1 = 5'b11101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic decValid = 1'b0;
  logic [N-1:0] decBits = '0;
  logic [K-2:0] bestState = '0;
  logic outValidSh, outBitSh, outValidSel, outBitSel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [N-1:0] decHist[$];
  int           bestHist[$];
  logic         srcQ[$];
  int           outIdx = 0;
  int           pm[N];

  always #(CLK_PERIOD / 2) clk = ~clk;

  survivor_xchg_mem #(.K(K), .D(D), .UPDATE(sxm_pkg::UPD_SHIFT)) i_survivor_xchg_mem (
    .clk(clk), .rst(rst), .dec_valid(decValid), .dec_bits(decBits),
    .best_state(bestState), .out_valid(outValidSh), .out_bit(outBitSh));

  survivor_xchg_mem #(.K(K), .D(D), .UPDATE(sxm_pkg::UPD_SELECT)) i_survivor_xchg_memSel (
    .clk(clk), .rst(rst), .dec_valid(decValid), .dec_bits(decBits),
    .best_state(bestState), .out_valid(outValidSel), .out_bit(outBitSel));

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b (step %0d)", req, act, exp, decHist.size());
    end
  endtask

  // Walk the stored decisions back D-1 steps from the best state (R4, R5, R6)
  function automatic logic walkBack();
    int t  = decHist.size() - 1;
    int st = bestHist[t];
    for (int j = t; j > t - (D - 1); j--) begin
      logic d = decHist[j][st];
      st = (d ? 0 : N / 2) | (st >> 1);
    end
    return logic'(st % 2);
  endfunction

  function automatic int encSym(int prevState, int u);
    int r = (prevState << 1) | u;
    return ((^(r & G0)) << 1) | (^(r & G1));
  endfunction

  function automatic int ham2(int a);
    return (a & 1) + ((a >> 1) & 1);
  endfunction

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    decValid = 1'b0;
    @(negedge clk);
    chk("R1 shift out_valid after reset", outValidSh, 1'b0);
    chk("R1 select out_valid after reset", outValidSel, 1'b0);
    rst = 1'b0;
    decHist.delete();
    bestHist.delete();
  endtask

  // Present one step at a negedge, sample at the following negedge
  task automatic doStep(logic [N-1:0] d, int b, bit cmpSrc);
    logic expValid, expBit;
    decBits   = d;
    bestState = (K-1)'(b);
    decValid  = 1'b1;
    decHist.push_back(d);
    bestHist.push_back(b);
    @(posedge clk);
    @(negedge clk);
    decValid = 1'b0;
    expValid = (decHist.size() >= D);
    chk("R2 R10 shift out_valid", outValidSh, expValid);
    chk("R2 R10 select out_valid", outValidSel, expValid);
    if (expValid) begin
      expBit = walkBack();
      chk("R6 R7 shift out_bit", outBitSh, expBit);
      chk("R6 R8 select out_bit", outBitSel, expBit);
      if (cmpSrc) begin
        chk("R9 decoded vs source", outBitSh, srcQ[outIdx]);
        outIdx++;
      end
    end
  endtask

  task automatic doIdle(int cycles);
    logic holdSh = outBitSh;
    logic holdSel = outBitSel;
    for (int i = 0; i < cycles; i++) begin
      decBits = N'($urandom);
      bestState = (K-1)'($urandom);
      @(negedge clk);
      chk("R3 shift idle out_valid", outValidSh, 1'b0);
      chk("R3 shift idle out_bit", outBitSh, holdSh);
      chk("R3 select idle out_bit", outBitSel, holdSel);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    // Scenario A: arbitrary decisions, idle gaps (R2..R8)
    doReset();
    for (int t = 0; t < 160; t++) begin
      doStep(N'($urandom), int'($urandom % N), 1'b0);
      if (t % 23 == 7) doIdle(3);
    end
    // All-upper and all-lower decisions (R4, R5)
    for (int t = 0; t < 40; t++) doStep('1, t % N, 1'b0);
    for (int t = 0; t < 40; t++) doStep('0, (t * 5) % N, 1'b0);

    // Scenario B: mid-stream reset then coded data with sparse errors (R10, R9)
    doReset();
    begin
      int encState = 0;
      pm[0] = 0;
      for (int s = 1; s < N; s++) pm[s] = 100;
      srcQ.delete();
      outIdx = 0;
      for (int t = 0; t < 420; t++) begin
        int u = (t >= 395) ? 0 : int'($urandom % 2);
        int rx = encSym(encState, u);
        int npm[N];
        int minPm = 1 << 30;
        int bestS = 0;
        logic [N-1:0] dv;
        srcQ.push_back(logic'(u));
        encState = ((encState << 1) | u) & (N - 1);
        if (t % 41 == 13) rx = rx ^ (1 << (t % 2));
        for (int s = 0; s < N; s++) begin
          int pu = s >> 1;
          int pl = (s >> 1) | (N / 2);
          int cu = pm[pu] + ham2(encSym(pu, s % 2) ^ rx);
          int cl = pm[pl] + ham2(encSym(pl, s % 2) ^ rx);
          dv[s]  = (cu <= cl);
          npm[s] = (cu <= cl) ? cu : cl;
          if (npm[s] < minPm) begin
            minPm = npm[s];
            bestS = s;
          end
        end
        for (int s = 0; s < N; s++) pm[s] = npm[s] - minPm;
        doStep(dv, bestS, 1'b1);
        if (t % 97 == 50) doIdle(2);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule